// File: doc/BRIEF.md
# Codec Register Configuration Sequencer

After reset, an audio codec has to be loaded with a short, fixed set of control words before it produces or accepts sound. This block does that loading. A one-cycle `start` pulse makes it write ten 16-bit control words to the codec, one after another, over a two-wire serial bus compatible with I2C. The block is always the bus master and the codec is always a slave. Each word is sent as its own write: a start condition, the device address byte with the write bit, the upper byte of the word, the lower byte, and a stop condition. After every byte the codec's acknowledge is checked.

The data line is open-drain. The block never drives it high. `sda_oe` high pulls the line low, and `sda_oe` low releases it to the external pull-up. The pad is `sda = sda_oe ? 1'b0 : 1'bz`, and the pad's input value returns on `sda_in`. A prescaler divides the system clock into ticks (`TICK_DIV` clocks each). Each serial bit lasts three ticks, and with the default of 8 the 12 MHz clock gives a 500 kHz bit rate. If an acknowledge is missing, the block closes the bus with a stop and halts with `error` set. If all ten words are acknowledged, it halts with `done` set.

States:
- `ST_IDLE`: after reset.
- `ST_STA_SDA` then `ST_STA_SCL`: the start condition.
- `ST_DATA`: eight bits, three phases each.
- `ST_ACK`: the acknowledge slot.
- `ST_STP_SCL_LO`, `ST_STP_SCL_HI`, `ST_STP_SDA_HI`: the stop condition.
- `ST_FINISH` and `ST_FAULT`: the two resting end states.

Transitions:
- Start pulse: `ST_IDLE`, `ST_FINISH` or `ST_FAULT` go to `ST_STA_SDA`. The word index is cleared.
- Tick: start steps to `ST_DATA`.
- After the eighth bit: `ST_DATA` goes to `ST_ACK`.
- After an acknowledge: `ST_ACK` goes back to `ST_DATA` for the next byte, or to the stop states after the third byte or after a missing acknowledge.
- End of stop: `ST_STP_SDA_HI` goes to `ST_FAULT` on a missing acknowledge, to `ST_FINISH` after the tenth word, or else to `ST_STA_SDA` with the next word.

Top module: `codec_cfg_seq`

## Requirements
- R1: After reset, and while resting, `scl` is 1 and `sda_oe` is 0 (bus released).
- R1: After reset, `done` and `error` are both 0.
- R2: The first byte of every write is 0x34. This is device address 0011010 followed by write bit 0.
- R3: The second and third bytes are bits 15:8 and 7:0 of the control word, sent MSB first. Bits 15:9 of each word form its register address, and bits 8:0 form the register data.
- R4: The words go out in this order: 0x0097, 0x0297, 0x0479, 0x0679, 0x0815, 0x0A00, 0x0C00, 0x0E42, 0x1019, 0x1201. The register addresses are therefore 0 to 9 in turn.
- R5: Start pulls SDA low while SCL is high, then pulls SCL low. Stop raises SCL while SDA is held low, then releases SDA. At no other time does SDA change on the same clock that SCL changes, or while SCL is high.
- R6: Each bit spans 3 ticks, with SCL high in the middle tick. Start is 2 ticks and stop is 3 ticks. A full run of ten writes therefore reaches `done` 860 ticks after the start pulse is taken.
- R7: During the acknowledge slot after each byte, `sda_oe` is 0. The value on `sda_in` sampled during the high SCL tick is the acknowledge.
- R8: An acknowledge read as 1 causes a stop right after that slot. It also sets `error`, sends no further byte or word, and leaves the bus released. `error` stays set until the next start.
- R9: `done` rises only after the stop of the tenth word has released SDA. It stays high until the next start.
- R10: A start pulse while a write sequence is running has no effect on the bytes sent or on the timing.
- R11: A start pulse taken in `ST_FINISH` or `ST_FAULT` clears both flags and restarts the list from the first word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin the write sequence |
| sda_in | input | 1 | Sampled value of the serial data line |
| scl | output | 1 | Serial clock |
| sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |
| done | output | 1 | All words written and acknowledged |
| error | output | 1 | A write was not acknowledged; sequence halted |

## Verification
Most faults in the internal state show up in the decoded bus traffic within one byte, about 24 ticks. A wrong phase counter produces a spurious start or stop, or a bit period other than three ticks. A wrong bit or byte index produces a corrupted byte. A wrong word index produces a register address that does not step 0 to 9. A sequencing fault in the end states shows up as a cycle-exact mismatch in when `done` rises, or as more or fewer writes after an unacknowledged byte. Random positions for the missing acknowledge, and start pulses injected mid-run, cover the abort path and the ignore-while-busy path.

// File: rtl/codec_cfg_pkg.sv
package codec_cfg_pkg;

    localparam int WORD_W   = 16;
    localparam int BYTE_W   = 8;
    localparam int XFER_BYTES = 1 + WORD_W / BYTE_W;
    localparam logic [6:0] DEV_ADDR = 7'b0011010;
    localparam logic [BYTE_W-1:0] ADDR_BYTE = {DEV_ADDR, 1'b0};

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_STA_SDA,
        ST_STA_SCL,
        ST_DATA,
        ST_ACK,
        ST_STP_SCL_LO,
        ST_STP_SCL_HI,
        ST_STP_SDA_HI,
        ST_FINISH,
        ST_FAULT
    } seq_state_t;

    // Ordered codec setup list; register address in [15:9], data in [8:0].
    function automatic logic [WORD_W-1:0] init_word(input int idx);
        case (idx)
            0:       return 16'h0097;
            1:       return 16'h0297;
            2:       return 16'h0479;
            3:       return 16'h0679;
            4:       return 16'h0815;
            5:       return 16'h0A00;
            6:       return 16'h0C00;
            7:       return 16'h0E42;
            8:       return 16'h1019;
            9:       return 16'h1201;
            default: return 16'h0000;
        endcase
    endfunction

endpackage

// File: rtl/codec_cfg_tick.sv
module codec_cfg_tick #(
    parameter int TICK_DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CNT_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TICK_DIV - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (!run || cnt == CNT_LAST)
            cnt <= '0;
        else
            cnt <= cnt + CNT_W'(1);
    end

    assign tick = run && (cnt == CNT_LAST);
endmodule

// File: rtl/codec_cfg_rom.sv
module codec_cfg_rom
    import codec_cfg_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic [IDX_W-1:0]  idx,
    output logic [WORD_W-1:0] word
);
    always_comb word = init_word(int'(idx));
endmodule

// File: rtl/codec_cfg_bitsel.sv
module codec_cfg_bitsel
    import codec_cfg_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    input  logic [1:0]        byte_idx,
    input  logic [2:0]        bit_idx,
    output logic              bit_out
);
    logic [BYTE_W-1:0] xfer [XFER_BYTES];
    logic [BYTE_W-1:0] cur;

    for (genvar g = 0; g < XFER_BYTES; g++) begin : g_byte
        if (g == 0) begin : g_addr
            assign xfer[g] = ADDR_BYTE;
        end else begin : g_word
            assign xfer[g] = word[WORD_W-1-(g-1)*BYTE_W -: BYTE_W];
        end
    end

    always_comb begin
        cur = '0;
        for (int k = 0; k < XFER_BYTES; k++)
            if (byte_idx == 2'(k)) cur = xfer[k];
        bit_out = cur[3'd7 - bit_idx];
    end
endmodule

// File: rtl/codec_cfg_seq.sv
module codec_cfg_seq
    import codec_cfg_pkg::*;
#(
    parameter int TICK_DIV  = 8,
    parameter int BIT_TICKS = 3,
    parameter int NUM_WORDS = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic sda_in,
    output logic scl,
    output logic sda_oe,
    output logic done,
    output logic error
);
    localparam int IDX_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;
    localparam int PH_W  = $clog2(BIT_TICKS);
    localparam logic [PH_W-1:0]  PH_LAST   = PH_W'(BIT_TICKS - 1);
    localparam logic [PH_W-1:0]  PH_SAMPLE = PH_W'(BIT_TICKS - 2);
    localparam logic [IDX_W-1:0] WORD_LAST = IDX_W'(NUM_WORDS - 1);
    localparam logic [1:0]       BYTE_LAST = 2'(XFER_BYTES - 1);

    seq_state_t       state, state_d;
    logic [IDX_W-1:0] word_idx, word_d;
    logic [1:0]       byte_idx, byte_d;
    logic [2:0]       bit_idx, bit_d;
    logic [PH_W-1:0]  phase, phase_d;
    logic             nack, nack_d;
    logic             tick, resting, tx_bit, scl_high_ph;
    logic [WORD_W-1:0] cur_word;

    assign resting = (state == ST_IDLE) || (state == ST_FINISH) || (state == ST_FAULT);

    codec_cfg_tick #(.TICK_DIV(TICK_DIV)) tick_i (
        .clk(clk), .rst_n(rst_n), .run(!resting), .tick(tick)
    );

    codec_cfg_rom #(.IDX_W(IDX_W)) rom_i (.idx(word_idx), .word(cur_word));

    codec_cfg_bitsel bitsel_i (
        .word(cur_word), .byte_idx(byte_idx), .bit_idx(bit_idx), .bit_out(tx_bit)
    );

    // next-state and counter logic
    always_comb begin
        state_d = state;
        word_d  = word_idx;
        byte_d  = byte_idx;
        bit_d   = bit_idx;
        phase_d = phase;
        nack_d  = nack;
        unique case (state)
            ST_IDLE, ST_FINISH, ST_FAULT: begin
                if (start) begin
                    state_d = ST_STA_SDA;
                    word_d  = '0;
                    byte_d  = '0;
                    bit_d   = '0;
                    phase_d = '0;
                    nack_d  = 1'b0;
                end
            end
            ST_STA_SDA: if (tick) state_d = ST_STA_SCL;
            ST_STA_SCL: begin
                if (tick) begin
                    state_d = ST_DATA;
                    byte_d  = '0;
                    bit_d   = '0;
                    phase_d = '0;
                end
            end
            ST_DATA: begin
                if (tick) begin
                    if (phase == PH_LAST) begin
                        phase_d = '0;
                        if (bit_idx == 3'd7) begin
                            bit_d   = '0;
                            state_d = ST_ACK;
                        end else begin
                            bit_d = bit_idx + 3'd1;
                        end
                    end else begin
                        phase_d = phase + PH_W'(1);
                    end
                end
            end
            ST_ACK: begin
                if (tick) begin
                    if (phase == PH_SAMPLE && sda_in) nack_d = 1'b1;
                    if (phase == PH_LAST) begin
                        phase_d = '0;
                        if (nack || byte_idx == BYTE_LAST) begin
                            state_d = ST_STP_SCL_LO;
                        end else begin
                            byte_d  = byte_idx + 2'd1;
                            state_d = ST_DATA;
                        end
                    end else begin
                        phase_d = phase + PH_W'(1);
                    end
                end
            end
            ST_STP_SCL_LO: if (tick) state_d = ST_STP_SCL_HI;
            ST_STP_SCL_HI: if (tick) state_d = ST_STP_SDA_HI;
            ST_STP_SDA_HI: begin
                if (tick) begin
                    if (nack) begin
                        state_d = ST_FAULT;
                    end else if (word_idx == WORD_LAST) begin
                        state_d = ST_FINISH;
                    end else begin
                        word_d  = word_idx + IDX_W'(1);
                        state_d = ST_STA_SDA;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            word_idx <= '0;
            byte_idx <= '0;
            bit_idx  <= '0;
            phase    <= '0;
            nack     <= 1'b0;
        end else begin
            state    <= state_d;
            word_idx <= word_d;
            byte_idx <= byte_d;
            bit_idx  <= bit_d;
            phase    <= phase_d;
            nack     <= nack_d;
        end
    end

    // outputs
    assign scl_high_ph = (phase != '0) && (phase != PH_LAST);

    always_comb begin
        scl    = 1'b1;
        sda_oe = 1'b0;
        done   = 1'b0;
        error  = 1'b0;
        unique case (state)
            ST_IDLE:       ;
            ST_FINISH:     done = 1'b1;
            ST_FAULT:      error = 1'b1;
            ST_STA_SDA:    sda_oe = 1'b1;
            ST_STA_SCL:    begin scl = 1'b0; sda_oe = 1'b1; end
            ST_DATA:       begin scl = scl_high_ph; sda_oe = !tx_bit; end
            ST_ACK:        scl = scl_high_ph;
            ST_STP_SCL_LO: begin scl = 1'b0; sda_oe = 1'b1; end
            ST_STP_SCL_HI: sda_oe = 1'b1;
            ST_STP_SDA_HI: ;
            default:       ;
        endcase
    end
endmodule

// File: rtl/codec_cfg_seq_chk.sv
module codec_cfg_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic scl,
    input logic sda_oe,
    input logic done,
    input logic error
);
    assert_rest_bus_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (done || error) |-> (scl && !sda_oe));

    assert_scl_rise_sda_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl) |-> $stable(sda_oe));

    assert_scl_fall_sda_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(scl) |-> $stable(sda_oe));

    assert_flags_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && error));

    assert_error_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (error && !start) |=> error);

    assert_done_after_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> ($past(scl) && !$past(sda_oe)));

    assert_done_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);
endmodule

bind codec_cfg_seq codec_cfg_seq_chk chk_i (
    .clk(clk), .rst_n(rst_n), .start(start), .scl(scl),
    .sda_oe(sda_oe), .done(done), .error(error)
);

// File: tb/codec_cfg_seq_tb.sv
module codec_cfg_seq_tb_top;
    localparam int DIV = 8;
    localparam int BIT_CLKS = 3 * DIV;
    localparam int WORD_TICKS = 2 + 3 * 9 * 3 + 3;
    localparam int FULL_CLKS = 10 * WORD_TICKS * DIV + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic sda_in, scl, sda_oe, done, error;
    logic slave_pull = 1'b0;

    always #2.5 clk = ~clk;

    assign sda_in = !sda_oe && !slave_pull;

    codec_cfg_seq #(.TICK_DIV(DIV)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .sda_in(sda_in),
        .scl(scl), .sda_oe(sda_oe), .done(done), .error(error)
    );

    int n_checks = 0;
    int n_fail = 0;

    // slave model and bus decoder
    logic       log_clr = 1'b0;
    int         nack_at = -1;
    logic [7:0] tbytes [0:15][0:3];
    int         tnb [0:15];
    int         ntrans = 0, nb = 0, bitcnt = 0, gbyte = 0;
    int         oe_viol = 0, per_viol = 0, ack_slots = 0;
    int         mcyc = 0, last_rise = 0;
    logic       in_xfer = 1'b0, prev_scl = 1'b1, prev_line = 1'b1;
    logic [7:0] shreg = '0;

    always @(negedge clk) begin
        logic line;
        line = !sda_oe && !slave_pull;
        mcyc++;
        if (log_clr) begin
            ntrans = 0; nb = 0; bitcnt = 0; gbyte = 0; in_xfer = 1'b0;
            oe_viol = 0; per_viol = 0; ack_slots = 0; slave_pull = 1'b0;
        end else if (prev_scl && scl && prev_line && !line) begin
            in_xfer = 1'b1; nb = 0; bitcnt = 0;
        end else if (prev_scl && scl && !prev_line && line) begin
            if (in_xfer && ntrans < 16) begin tnb[ntrans] = nb; ntrans++; end
            in_xfer = 1'b0;
        end else if (!prev_scl && scl && in_xfer) begin
            if (bitcnt >= 1 && bitcnt <= 8 && (mcyc - last_rise) != BIT_CLKS) per_viol++;
            last_rise = mcyc;
            if (bitcnt < 8) shreg = {shreg[6:0], line};
            else begin ack_slots++; if (sda_oe) oe_viol++; end
            bitcnt++;
        end else if (prev_scl && !scl && in_xfer) begin
            if (bitcnt == 8) slave_pull = (gbyte != nack_at);
            else if (bitcnt == 9) begin
                slave_pull = 1'b0;
                if (ntrans < 16 && nb < 4) tbytes[ntrans][nb] = shreg;
                nb++; gbyte++; bitcnt = 0;
            end
        end
        prev_scl = scl;
        prev_line = line;
    end

    function automatic logic [15:0] exp_word(input int w);
        case (w)
            0: return 16'h0097; 1: return 16'h0297; 2: return 16'h0479;
            3: return 16'h0679; 4: return 16'h0815; 5: return 16'h0A00;
            6: return 16'h0C00; 7: return 16'h0E42; 8: return 16'h1019;
            9: return 16'h1201; default: return 16'h0000;
        endcase
    endfunction

    function automatic logic [7:0] exp_byte(input int w, input int b);
        logic [15:0] x;
        x = exp_word(w);
        if (b == 0) return 8'h34;
        return (b == 1) ? x[15:8] : x[7:0];
    endfunction

    task automatic chk(input string req, input bit ok, input string what, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic check_bytes(input int w, input int upto);
        bit addr_ok = 1, data_ok = 1;
        for (int b = 0; b < upto; b++) begin
            if (b == 0 && tbytes[w][b] != exp_byte(w, b)) addr_ok = 0;
            if (b > 0 && tbytes[w][b] != exp_byte(w, b)) data_ok = 0;
        end
        chk("R2", addr_ok, $sformatf("address byte of write %0d", w), int'(tbytes[w][0]), 8'h34);
        if (upto > 1)
            chk("R4", data_ok, $sformatf("word bytes of write %0d", w),
                int'({tbytes[w][1], tbytes[w][2]}), int'(exp_word(w)));
        if (upto == 3)
            chk("R3", ({tbytes[w][1], tbytes[w][2]} >> 9) == 16'(w),
                $sformatf("register address field of write %0d", w),
                int'({tbytes[w][1], tbytes[w][2]} >> 9), w);
    endtask

    // one sequence: nack_pos < 0 means all acknowledged
    task automatic do_run(input int nack_pos, input int busy_at, input bit check_time);
        int n;
        @(posedge clk) log_clr = 1'b1;
        nack_at = nack_pos;
        @(posedge clk) log_clr = 1'b0;
        @(negedge clk) start = 1'b1;
        n = 0;
        do begin
            @(posedge clk);
            n++;
            @(negedge clk);
            start = (busy_at != 0 && n == busy_at);
            if (n == 1) chk("R11", !done && !error, "flags clear after start", int'({done, error}), 0);
        end while (!done && !error && n < 20000);
        chk("R6", n < 20000, "sequence ends", n, FULL_CLKS);
        chk("R6", per_viol == 0, "bit period deviations", per_viol, 0);
        chk("R7", oe_viol == 0 && ack_slots > 0, "master drives in ack slot", oe_viol, 0);
        if (nack_pos < 0) begin
            chk("R9", done && !error, "done after full list", int'({done, error}), 2);
            chk("R4", ntrans == 10, "write count", ntrans, 10);
            for (int w = 0; w < 10 && w < ntrans; w++) begin
                chk("R2", tnb[w] == 3, $sformatf("bytes in write %0d", w), tnb[w], 3);
                check_bytes(w, 3);
            end
            if (check_time)
                chk(busy_at != 0 ? "R10" : "R6", n == FULL_CLKS, "cycles start to done", n, FULL_CLKS);
            repeat (40) @(negedge clk);
            chk("R9", done && scl && !sda_oe, "done held, bus released", int'({done, scl, sda_oe}), 6);
        end else begin
            int w = nack_pos / 3;
            chk("R8", error && !done, $sformatf("error on nack at byte %0d", nack_pos), int'({done, error}), 1);
            repeat (200) @(negedge clk);
            chk("R8", ntrans == w + 1, "writes before halt", ntrans, w + 1);
            chk("R8", error && scl && !sda_oe, "halted, bus released", int'({error, scl, sda_oe}), 6);
            for (int k = 0; k < w && k < ntrans; k++) check_bytes(k, 3);
            if (ntrans > w) begin
                chk("R8", tnb[w] == nack_pos % 3 + 1, "bytes in aborted write", tnb[w], nack_pos % 3 + 1);
                check_bytes(w, tnb[w] < 4 ? tnb[w] : 3);
            end
        end
    endtask

    initial begin
        repeat (15000 * 10) @(posedge clk);
        $display("FAIL R6 watchdog expired: actual hung expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks + 1, n_fail + 1);
        $finish;
    end

    initial begin
        void'($urandom(32'd51977));
        repeat (3) @(negedge clk);
        chk("R1", scl && !sda_oe, "bus idle in reset", int'({scl, sda_oe}), 2);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk("R1", scl && !sda_oe && !done && !error, "idle after reset",
            int'({scl, sda_oe, done, error}), 8);

        do_run(-1, 0, 1);                 // full list
        do_run(-1, 0, 1);                 // restart from finish (R11)
        do_run(0, 0, 0);                  // nack on very first address byte
        do_run(29, 0, 0);                 // nack on last byte of last word
        do_run(-1, 0, 1);                 // restart from fault (R11)
        for (int r = 0; r < 4; r++)
            do_run(int'($urandom_range(29, 0)), 0, 0);
        for (int r = 0; r < 2; r++)       // start pulse while busy (R10)
            do_run(-1, int'($urandom_range(FULL_CLKS - 50, 100)), 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule